// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block sits on a simple register write bus in front of a group of protected configuration registers: control, init-mode bit, prescaler, time, date and alarm. Writes to those registers pass only while the lock is open. The lock opens when software writes a first key byte and then a second key byte to a dedicated key register. The two key writes must be consecutive writes on the bus. Writing any value other than the expected one to the key register closes the lock again.

For every write, the block computes an accept signal in the same cycle. The register file downstream qualifies its write enable with that signal. A registered unlocked flag reports whether the lock is currently open. The key register always takes writes, and so does every address outside the protected window. Only the low byte of a key-register write is compared.

Top module: `keylock_top`

## Requirements
- R1: After reset the lock is closed: `unlocked` is 0 and a write to any protected address sees `wr_accept` = 0.
- R2: A key-register write with low byte 0xCA, then a key-register write with low byte 0x53 as the very next bus write, opens the lock. `unlocked` reads 1 from the clock edge that captures the second key.
- R3: A key-register write of 0x53 that does not directly follow a 0xCA key write leaves the lock closed.
- R4: After a first key, a key-register write whose low byte is neither 0x53 nor 0xCA closes the lock. A repeated 0xCA instead stays armed as a new first key, so 0xCA, 0xCA, 0x53 opens the lock.
- R5: After a first key, any write to an address other than the key register cancels the sequence, and a following 0x53 leaves the lock closed.
- R6: While the lock is open, any key-register write closes it. If the low byte of that write is 0xCA, it also counts as a first key, so a following 0x53 reopens the lock.
- R7: The protected addresses are PROT_BASE + i*PROT_STRIDE for i in 0..PROT_COUNT-1 (defaults 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14). A write to one of them has `wr_accept` equal to `unlocked`.
- R8: A write to the key register (default 0x3C) or to any address outside the protected set always has `wr_accept` = 1.
- R9: Only bits 7:0 of `wr_data` are compared against the keys. The upper bits are ignored.
- R10: With `wr_en` low, `wr_accept` is 0 and the lock state does not change, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| wr_accept | output | 1 | The current write may update its target register |
| unlocked | output | 1 | Protected registers are currently writable |

## Verification
`wr_accept` is combinational from the current write and the lock state. The bench therefore samples it a short delay after driving a write, before that write's clock edge. `unlocked` changes at the edge that captures a key write, so it is due one cycle after the write is presented. The bench samples it at the falling edge after that capture. Between writes the bench inserts idle cycles with `wr_en` low, which makes each "next write" unambiguous. Those idle cycles also confirm that idle bus cycles do not disturb an armed sequence.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam int unsigned KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hCA;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'h53;

    // Lock sequencer states
    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_t;

    // Classification of the write presented this cycle (at most one bit set)
    typedef struct packed {
        logic key_wr;
        logic prot_wr;
        logic other_wr;
    } wr_class_t;

    // Key byte carried from the bus to the sequencer
    typedef struct packed {
        logic             is_first;
        logic             is_second;
        logic [KEY_W-1:0] value;
    } key_info_t;

    function automatic key_info_t decode_key(input logic [KEY_W-1:0] b);
        key_info_t k;
        k.value     = b;
        k.is_first  = (b == KEY_FIRST);
        k.is_second = (b == KEY_SECOND);
        return k;
    endfunction

    function automatic lock_state_t next_on_key(input lock_state_t cur,
                                                input key_info_t   k);
        lock_state_t n;
        unique case (cur)
            LK_ARMED: n = k.is_second ? LK_OPEN  :
                          k.is_first  ? LK_ARMED : LK_CLOSED;
            default:  n = k.is_first  ? LK_ARMED : LK_CLOSED;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/keylock_decode.sv
module keylock_decode
    import keylock_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned KEY_ADDR    = 32'h3C,
    parameter int unsigned PROT_BASE   = 32'h00,
    parameter int unsigned PROT_STRIDE = 4,
    parameter int unsigned PROT_COUNT  = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_class_t         cls
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR);

    logic [PROT_COUNT-1:0] hit_vec;

    for (genvar i = 0; i < PROT_COUNT; i++) begin : g_prot
        localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(PROT_BASE + i * PROT_STRIDE);
        assign hit_vec[i] = (wr_addr == SLOT_A);
    end

    logic is_key;
    logic is_prot;

    always_comb begin
        is_key       = (wr_addr == KEY_A);
        is_prot      = (|hit_vec) && !is_key;
        cls.key_wr   = wr_en && is_key;
        cls.prot_wr  = wr_en && is_prot;
        cls.other_wr = wr_en && !is_key && !is_prot;
    end

endmodule

// File: rtl/keylock_seq.sv
module keylock_seq
    import keylock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_class_t   cls,
    input  key_info_t   key,
    output lock_state_t state,
    output logic        unlocked
);
    lock_state_t state_q;
    lock_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (cls.key_wr) begin
            state_d = next_on_key(state_q, key);
        end else if ((cls.prot_wr || cls.other_wr) && (state_q == LK_ARMED)) begin
            // any other write between the two keys cancels the sequence
            state_d = LK_CLOSED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state    = state_q;
    assign unlocked = (state_q == LK_OPEN);

endmodule

// File: rtl/keylock_gate.sv
module keylock_gate
    import keylock_pkg::*;
(
    input  wr_class_t cls,
    input  logic      unlocked,
    output logic      wr_accept
);
    always_comb begin
        wr_accept = cls.key_wr || cls.other_wr || (cls.prot_wr && unlocked);
    end
endmodule

// File: rtl/keylock_top.sv
module keylock_top
    import keylock_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned KEY_ADDR    = 32'h3C,
    parameter int unsigned PROT_BASE   = 32'h00,
    parameter int unsigned PROT_STRIDE = 4,
    parameter int unsigned PROT_COUNT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_accept,
    output logic              unlocked
);
    wr_class_t   wr_cls;
    key_info_t   key;
    lock_state_t lock_state;
    logic        prot_hit;

    assign key      = decode_key(wr_data[KEY_W-1:0]);
    assign prot_hit = wr_cls.prot_wr;

    keylock_decode #(
        .ADDR_W      (ADDR_W),
        .KEY_ADDR    (KEY_ADDR),
        .PROT_BASE   (PROT_BASE),
        .PROT_STRIDE (PROT_STRIDE),
        .PROT_COUNT  (PROT_COUNT)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cls     (wr_cls)
    );

    keylock_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cls      (wr_cls),
        .key      (key),
        .state    (lock_state),
        .unlocked (unlocked)
    );

    keylock_gate u_gate (
        .cls       (wr_cls),
        .unlocked  (unlocked),
        .wr_accept (wr_accept)
    );

endmodule

// File: rtl/keylock_chk.sv
module keylock_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned KEY_ADDR = 32'h3C
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_accept,
    input logic              unlocked,
    input logic              prot_hit
);
    logic key_write;
    assign key_write = wr_en && (wr_addr == ADDR_W'(KEY_ADDR));

    p_reset_closed_r1: assert property (@(posedge clk)
        rst |=> !unlocked);

    p_open_by_second_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_write && (wr_data[7:0] == 8'h53)));

    p_non_key_write_never_opens_r5: assert property (@(posedge clk) disable iff (rst)
        !key_write |=> !$rose(unlocked));

    p_wrong_key_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (key_write && (wr_data[7:0] != 8'h53)) |=> !unlocked);

    p_protected_follows_lock_r7: assert property (@(posedge clk) disable iff (rst)
        prot_hit |-> (wr_accept == unlocked));

    p_key_always_taken_r8: assert property (@(posedge clk) disable iff (rst)
        key_write |-> wr_accept);

    p_idle_no_accept_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_accept);

    p_idle_holds_state_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(unlocked));

endmodule

bind keylock_top keylock_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY_ADDR (KEY_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_accept (wr_accept),
    .unlocked  (unlocked),
    .prot_hit  (prot_hit)
);

// File: tb/keylock_top_tb_top.sv
module keylock_top_tb_top;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam logic [7:0] KADDR = 8'h3C;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_accept;
    logic              unlocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    keylock_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_accept (wr_accept),
        .unlocked  (unlocked)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // one write: drive at negedge, sample accept before the edge, idle after
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic acc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1 acc = wr_accept;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key(input logic [31:0] d);
        logic acc;
        wr(KADDR, d, acc);
    endtask

    task automatic relock();
        key(32'hFF);
    endtask

    task automatic t_reset();
        logic acc;
        check("R1 unlocked after reset", unlocked, 1'b0);
        wr(8'h04, 32'h1, acc);
        check("R1 protected write refused", acc, 1'b0);
    endtask

    task automatic t_unlock();
        logic acc;
        key(32'hCA);
        check("R2 closed after first key", unlocked, 1'b0);
        key(32'h53);
        check("R2 open after second key", unlocked, 1'b1);
        for (int i = 0; i < 6; i++) begin
            wr(8'(i * 4), 32'h5A, acc);
            check("R7 protected write accepted when open", acc, 1'b1);
        end
        relock();
        check("R6 wrong key closes", unlocked, 1'b0);
        wr(8'h14, 32'h0, acc);
        check("R7 last protected slot refused when closed", acc, 1'b0);
    endtask

    task automatic t_second_alone();
        key(32'h53);
        check("R3 lone second key", unlocked, 1'b0);
    endtask

    task automatic t_wrong_second();
        key(32'hCA); key(32'h11); key(32'h53);
        check("R4 bad second value resets", unlocked, 1'b0);
        key(32'hCA); key(32'hCA); key(32'h53);
        check("R4 repeated first key rearms", unlocked, 1'b1);
        relock();
    endtask

    task automatic t_intervening();
        logic acc;
        key(32'hCA);
        wr(8'h20, 32'h0, acc);
        key(32'h53);
        check("R5 other write cancels", unlocked, 1'b0);
        key(32'hCA);
        wr(8'h00, 32'h0, acc);
        check("R7 protected refused while armed", acc, 1'b0);
        key(32'h53);
        check("R5 protected write cancels", unlocked, 1'b0);
    endtask

    task automatic t_open_first();
        key(32'hCA); key(32'h53);
        key(32'hCA);
        check("R6 first key closes open lock", unlocked, 1'b0);
        key(32'h53);
        check("R6 first key while open rearms", unlocked, 1'b1);
        key(32'h53);
        check("R6 second key while open closes", unlocked, 1'b0);
    endtask

    task automatic t_low_byte();
        key(32'hABCD_00CA); key(32'hFFFF_FF53);
        check("R9 upper bits ignored on keys", unlocked, 1'b1);
        key(32'h0000_CA00);
        check("R9 low byte 00 closes", unlocked, 1'b0);
    endtask

    task automatic t_always();
        logic acc;
        wr(KADDR, 32'h77, acc);
        check("R8 key register accepted when closed", acc, 1'b1);
        wr(8'h20, 32'h1, acc);
        check("R8 unprotected address accepted", acc, 1'b1);
        wr(8'h18, 32'h1, acc);
        check("R8 first address past window accepted", acc, 1'b1);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        wr_en = 1'b0; wr_addr = KADDR; wr_data = 32'hCA;
        #1 check("R10 no accept without strobe", wr_accept, 1'b0);
        @(negedge clk);
        wr_data = 32'h53;
        @(negedge clk);
        @(negedge clk);
        check("R10 idle key values do not open", unlocked, 1'b0);
        wr_addr = 8'h04;
        #1 check("R10 no accept on idle protected address", wr_accept, 1'b0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unlock();
        t_second_alone();
        t_wrong_second();
        t_intervening();
        t_open_first();
        t_low_byte();
        t_always();
        t_no_strobe();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule